// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a system with 4 KiB pages. The address is cut into a 10-bit root index (bits 31:22), a 10-bit leaf index (bits 21:12) and a 12-bit byte offset. The physical address is the 20-bit frame number joined to that unchanged offset.

An 8-entry fully associative translation cache is searched first. On a miss, a controller reads the root-table entry through a single memory port. It then reads the leaf-table entry, and it writes the leaf entry back with its usage flags updated. It then loads the mapping into the cache. Either missing level ends the walk with a page fault. Only one translation is in flight at a time.

Every table entry is a 32-bit word. Bits 31:12 hold the frame number, bit 0 is the present flag, bit 5 is the accessed flag and bit 6 is the dirty flag. The root table sits in the frame given by `tableFrame`.

Top module: `xlate_top`

## Requirements
- R1: After reset `reqReady` is 1, and `rspValid`, `memRdEn` and `memWrEn` are 0. No memory access happens while no translation is pending.
- R2: The root entry is read at byte address {tableFrame, va[31:22], 2'b00}.
- R3: If the root entry has bit 0 clear, the response is a fault 4 cycles after acceptance, with exactly one memory read and no write.
- R4: The leaf entry is read at {rootEntry[31:12], va[21:12], 2'b00}. If its bit 0 is clear, the response is a fault 6 cycles after acceptance, with two reads and no write.
- R5: A successful walk responds 7 cycles after acceptance with two reads and one write. The result is `rspPa` = {leafEntry[31:12], va[11:0]} and `rspFault` = 0.
- R6: The write-back rewrites the leaf entry with bit 5 set, bit 6 set when the request is a write, and all other bits unchanged.
- R7: A cache hit responds 2 cycles after acceptance with no memory access. It uses the cached frame even if the table in memory has since changed.
- R8: A write whose page is cached without its dirty flag is handled as a miss. The full walk sets bit 6, and later writes to that page hit.
- R9: The cache holds 8 pages. A new page goes into the slot after the last new page, in a fixed cycle. A page that is already cached is refilled in place.
- R10: A one-cycle pulse on `flush` invalidates every cached page.
- R11: `reqReady` is 0 from the acceptance edge until the response. `rspValid` is a single-cycle pulse. Reads and writes are never issued together.
- R12: A faulting response carries `rspPa` = 0 and caches nothing, so repeating the request walks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block can accept a request |
| reqVa | input | 32 | Virtual address |
| reqWrite | input | 1 | Request is a store |
| tableFrame | input | 20 | Frame number of the root table |
| memRdEn | output | 1 | Memory read strobe; data is due the next cycle |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data |
| rspValid | output | 1 | Response pulse |
| rspPa | output | 32 | Physical address |
| rspFault | output | 1 | Page fault |

## Verification
The hardest case to reach from the ports is a store to a page that the cache already holds without its dirty flag. It needs a cache hit on the tag and a miss on the dirty check at the same time. Directed loads followed by stores to the same page reach it. Random stimulus over a small set of pages also reaches it often.

Cache eviction is the second hard case. It appears only after eight distinct successful walks, so a directed sweep over nine pages of one leaf table drives it. A bench model of the cache predicts hit or miss for each request. Each response is checked for latency and for its exact memory read and write counts.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int BIT_P   = 0;
  localparam int BIT_A   = 5;
  localparam int BIT_D   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_L1RD, ST_L1CHK, ST_L2RD, ST_L2CHK, ST_L2WR, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic latchReq;
    logic latchL1;
    logic latchPte;
    logic useL2Addr;
    logic tlbFill;
    logic setHitPa;
    logic setWalkPa;
    logic setFault;
  } walkCtl_t;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [TAG_W-1:0]   lookTag,
  output logic               hit,
  output logic               hitDirty,
  output logic [FRAME_W-1:0] hitFrame,
  input  logic               fill,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillDirty
);
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic               validQ [ENTRIES];
  logic [TAG_W-1:0]   tagQ   [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];
  logic               dirtyQ [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [SLOT_W-1:0]  matchIdx;
  logic [SLOT_W-1:0]  ptrQ;
  logic [SLOT_W-1:0]  fillSlot;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign matchVec[e] = validQ[e] && (tagQ[e] == lookTag);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        tagQ[e]   <= '0;
        frameQ[e] <= '0;
        dirtyQ[e] <= 1'b0;
      end else if (flush) begin
        validQ[e] <= 1'b0;
      end else if (fill && fillSlot == SLOT_W'(e)) begin
        validQ[e] <= 1'b1;
        tagQ[e]   <= lookTag;
        frameQ[e] <= fillFrame;
        dirtyQ[e] <= fillDirty;
      end
    end
  end

  always_comb begin
    hitFrame = '0;
    hitDirty = 1'b0;
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitFrame = hitFrame | frameQ[i];
        hitDirty = hitDirty | dirtyQ[i];
        matchIdx = SLOT_W'(i);
      end
    end
  end

  assign hit      = |matchVec;
  assign fillSlot = hit ? matchIdx : ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (fill && !flush && !hit) begin
      ptrQ <= (ptrQ == SLOT_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     tlbHit,
  input  logic     tlbDirty,
  input  logic     wrQ,
  input  logic     rdPresent,
  output logic     reqReady,
  output logic     memRdEn,
  output logic     memWrEn,
  output logic     rspValid,
  output walkCtl_t ctl
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    ctl      = '0;
    reqReady = 1'b0;
    memRdEn  = 1'b0;
    memWrEn  = 1'b0;
    rspValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateD       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (tlbHit && (!wrQ || tlbDirty)) begin
          ctl.setHitPa = 1'b1;
          stateD       = ST_DONE;
        end else begin
          stateD = ST_L1RD;
        end
      end
      ST_L1RD: begin
        memRdEn = 1'b1;
        stateD  = ST_L1CHK;
      end
      ST_L1CHK: begin
        if (rdPresent) begin
          ctl.latchL1 = 1'b1;
          stateD      = ST_L2RD;
        end else begin
          ctl.setFault = 1'b1;
          stateD       = ST_DONE;
        end
      end
      ST_L2RD: begin
        memRdEn       = 1'b1;
        ctl.useL2Addr = 1'b1;
        stateD        = ST_L2CHK;
      end
      ST_L2CHK: begin
        ctl.useL2Addr = 1'b1;
        if (rdPresent) begin
          ctl.latchPte = 1'b1;
          stateD       = ST_L2WR;
        end else begin
          ctl.setFault = 1'b1;
          stateD       = ST_DONE;
        end
      end
      ST_L2WR: begin
        memWrEn       = 1'b1;
        ctl.useL2Addr = 1'b1;
        ctl.tlbFill   = 1'b1;
        ctl.setWalkPa = 1'b1;
        stateD        = ST_DONE;
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  walkCtl_t           ctl,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic [FRAME_W-1:0] tableFrame,
  input  logic [VA_W-1:0]    memRdata,
  output logic [VA_W-1:0]    memAddr,
  output logic [VA_W-1:0]    memWdata,
  output logic [VA_W-1:0]    rspPa,
  output logic               rspFault,
  output logic               tlbHit,
  output logic               tlbDirty,
  output logic               wrQ
);
  logic [VA_W-1:0]    vaQ;
  logic [FRAME_W-1:0] l1FrameQ;
  logic [VA_W-1:0]    pteQ;
  logic [VA_W-1:0]    paQ;
  logic               faultQ;
  logic [FRAME_W-1:0] tlbFrame;

  logic [IDX_W-1:0]   rootIdx;
  logic [IDX_W-1:0]   leafIdx;
  logic [OFF_W-1:0]   pageOff;

  assign rootIdx = vaQ[VA_W-1 -: IDX_W];
  assign leafIdx = vaQ[OFF_W +: IDX_W];
  assign pageOff = vaQ[OFF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ      <= '0;
      wrQ      <= 1'b0;
      l1FrameQ <= '0;
      pteQ     <= '0;
      paQ      <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (ctl.latchReq) begin
        vaQ    <= reqVa;
        wrQ    <= reqWrite;
        paQ    <= '0;
        faultQ <= 1'b0;
      end
      if (ctl.latchL1)   l1FrameQ <= memRdata[VA_W-1:OFF_W];
      if (ctl.latchPte)  pteQ     <= memRdata;
      if (ctl.setHitPa)  paQ      <= {tlbFrame, pageOff};
      if (ctl.setWalkPa) paQ      <= {pteQ[VA_W-1:OFF_W], pageOff};
      if (ctl.setFault) begin
        faultQ <= 1'b1;
        paQ    <= '0;
      end
    end
  end

  always_comb begin
    if (ctl.useL2Addr) memAddr = {l1FrameQ, leafIdx, 2'b00};
    else               memAddr = {tableFrame, rootIdx, 2'b00};
  end

  always_comb begin
    memWdata        = pteQ;
    memWdata[BIT_A] = 1'b1;
    memWdata[BIT_D] = pteQ[BIT_D] | wrQ;
  end

  assign rspPa    = paQ;
  assign rspFault = faultQ;

  xlate_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .TAG_W   (FRAME_W),
    .FRAME_W (FRAME_W)
  ) u_tlb (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .lookTag   (vaQ[VA_W-1:OFF_W]),
    .hit       (tlbHit),
    .hitDirty  (tlbDirty),
    .hitFrame  (tlbFrame),
    .fill      (ctl.tlbFill),
    .fillFrame (pteQ[VA_W-1:OFF_W]),
    .fillDirty (pteQ[BIT_D] | wrQ)
  );
endmodule

// File: rtl/xlate_top.sv
module xlate_top
  import xlate_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic [FRAME_W-1:0] tableFrame,
  output logic               memRdEn,
  output logic               memWrEn,
  output logic [VA_W-1:0]    memAddr,
  output logic [VA_W-1:0]    memWdata,
  input  logic [VA_W-1:0]    memRdata,
  output logic               rspValid,
  output logic [VA_W-1:0]    rspPa,
  output logic               rspFault
);
  walkCtl_t ctl;
  logic     tlbHit;
  logic     tlbDirty;
  logic     wrQ;

  xlate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .tlbHit    (tlbHit),
    .tlbDirty  (tlbDirty),
    .wrQ       (wrQ),
    .rdPresent (memRdata[BIT_P]),
    .reqReady  (reqReady),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .rspValid  (rspValid),
    .ctl       (ctl)
  );

  xlate_dp #(.TLB_ENTRIES(TLB_ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .ctl        (ctl),
    .reqVa      (reqVa),
    .reqWrite   (reqWrite),
    .tableFrame (tableFrame),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .rspPa      (rspPa),
    .rspFault   (rspFault),
    .tlbHit     (tlbHit),
    .tlbDirty   (tlbDirty),
    .wrQ        (wrQ)
  );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [11:0] reqOff,
  input logic        reqWrite,
  input logic        memRdEn,
  input logic        memWrEn,
  input logic        wbPresent,
  input logic        wbAccessed,
  input logic        wbDirty,
  input logic        rspValid,
  input logic        rspFault,
  input logic [31:0] rspPa
);
  logic        busy;
  logic [11:0] offCap;
  logic        wrCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      offCap <= '0;
      wrCap  <= 1'b0;
    end else if (reqValid && reqReady) begin
      busy   <= 1'b1;
      offCap <= reqOff;
      wrCap  <= reqWrite;
    end else if (rspValid) begin
      busy <= 1'b0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !memWrEn)); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspPa[11:0] == offCap)); // R5
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (wbAccessed && wbPresent)); // R6
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && wrCap) |-> wbDirty); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R11
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPa == 32'd0)); // R12
endmodule

bind xlate_top xlate_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqOff     (reqVa[11:0]),
  .reqWrite   (reqWrite),
  .memRdEn    (memRdEn),
  .memWrEn    (memWrEn),
  .wbPresent  (memWdata[0]),
  .wbAccessed (memWdata[5]),
  .wbDirty    (memWdata[6]),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspPa      (rspPa)
);

// File: tb/tb_xlate_top.sv
`timescale 1ns/1ps
module tb_xlate_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic        reqWrite = 1'b0;
  logic [19:0] tableFrame = 20'd1;
  logic        memRdEn, memWrEn;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata;
  logic        rspValid;
  logic [31:0] rspPa;
  logic        rspFault;

  always #2.5 clk = ~clk;

  xlate_top dut (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqWrite(reqWrite), .tableFrame(tableFrame),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rspValid(rspValid), .rspPa(rspPa), .rspFault(rspFault)
  );

  // memory model: 4 frames of 4 KiB, read data due one cycle after the strobe
  bit   [31:0] mem [0:4095];
  logic [31:0] rdReg = '0;
  logic        pokeEn = 1'b0;
  logic [11:0] pokeIdx = '0;
  logic [31:0] pokeVal = '0;
  int          rdCnt = 0;
  int          wrCnt = 0;
  bit          addrBad = 1'b0;
  assign memRdata = rdReg;

  always @(posedge clk) begin
    if (memRdEn) begin rdReg <= mem[memAddr[13:2]]; rdCnt <= rdCnt + 1; end
    if (memWrEn) begin mem[memAddr[13:2]] <= memWdata; wrCnt <= wrCnt + 1; end
    if (pokeEn) mem[pokeIdx] <= pokeVal;
    if ((memRdEn || memWrEn) && memAddr[31:14] != 18'd0) addrBad <= 1'b1;
  end

  int checks = 0;
  int errors = 0;

  // cache model
  bit [19:0] mTag   [8];
  bit [19:0] mFrame [8];
  bit        mDirty [8];
  bit        mValid [8];
  int        mPtr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    @(negedge clk);
    pokeEn = 1'b1; pokeIdx = 12'(idx); pokeVal = val;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit wr, input string ctx);
    int hitSlot, expRd, expWr, expLat, pteIdx, lat, r0, w0;
    bit isHit, expFault, readyLow;
    logic [31:0] expPa, l1, pte, expPte;
    hitSlot = -1; pteIdx = 0; expPte = '0; expPa = '0;
    for (int i = 0; i < 8; i++) if (mValid[i] && mTag[i] == va[31:12]) hitSlot = i;
    isHit = (hitSlot >= 0) && (!wr || mDirty[hitSlot]);
    if (isHit) begin
      expPa = {mFrame[hitSlot], va[11:0]}; expFault = 0; expRd = 0; expWr = 0; expLat = 2;
    end else begin
      l1 = mem[1024 + int'(va[31:22])];
      if (!l1[0]) begin
        expFault = 1; expRd = 1; expWr = 0; expLat = 4;
      end else begin
        pteIdx = int'(l1[13:12]) * 1024 + int'(va[21:12]);
        pte = mem[pteIdx];
        if (!pte[0]) begin
          expFault = 1; expRd = 2; expWr = 0; expLat = 6;
        end else begin
          expFault = 0; expRd = 2; expWr = 1; expLat = 7;
          expPa = {pte[31:12], va[11:0]};
          expPte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
          if (hitSlot < 0) begin hitSlot = mPtr; mPtr = (mPtr + 1) % 8; end
          mValid[hitSlot] = 1; mTag[hitSlot] = va[19+12 -: 20];
          mFrame[hitSlot] = pte[31:12]; mDirty[hitSlot] = pte[6] | wr;
        end
      end
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    r0 = rdCnt; w0 = wrCnt;
    reqValid = 1'b1; reqVa = va; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; readyLow = 1;
    while (!rspValid && lat < 50) begin
      if (reqReady) readyLow = 0;
      @(negedge clk);
      lat++;
    end
    chk(readyLow, {ctx, " R11 ready low during walk"}, 0, 1);
    chk(lat == expLat, {ctx, isHit ? " R7 latency" : (expFault ? (expRd == 1 ? " R3 latency" : " R4 latency") : " R5 latency")}, lat, expLat);
    chk(rspFault == expFault, {ctx, expFault ? " R3/R4 fault" : " R5 fault flag"}, rspFault, expFault);
    chk(rspPa == expPa, {ctx, expFault ? " R12 fault pa" : (isHit ? " R7 pa" : " R5 pa")}, rspPa, expPa);
    chk((rdCnt - r0) == expRd, {ctx, isHit ? " R7 reads" : " R2/R4 reads"}, rdCnt - r0, expRd);
    chk((wrCnt - w0) == expWr, {ctx, " R6 writes"}, wrCnt - w0, expWr);
    if (expWr == 1) chk(mem[pteIdx] == expPte, {ctx, " R6 writeback"}, mem[pteIdx], expPte);
    @(negedge clk);
    chk(rspValid == 1'b0, {ctx, " R11 pulse"}, rspValid, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog R11 actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready in reset", reqReady, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady == 1'b1 && rspValid == 1'b0, "R1 idle outputs", {reqReady, rspValid}, 2);
    chk(rdCnt == 0 && wrCnt == 0 && !memRdEn && !memWrEn, "R1 no memory traffic", rdCnt + wrCnt, 0);

    // root table in frame 1: index 0 and 1023 -> frame 2, index 5 -> frame 3, index 7 absent
    poke(1024 + 0,    {20'd2, 12'h001});
    poke(1024 + 5,    {20'd3, 12'h001});
    poke(1024 + 1023, {20'd2, 12'h001});
    for (int i = 0; i < 16; i++) begin
      poke(2048 + i, {20'($urandom), 5'd0, 1'($urandom), 1'b0, 4'($urandom), 1'b1});
      poke(3072 + i, {20'($urandom), 5'd0, 1'($urandom), 1'b0, 4'($urandom), 1'($urandom)});
    end

    // R12 and R3: absent root entry, twice
    xlate(32'h01C0_0123, 0, "R12 first");
    xlate(32'h01C0_0123, 0, "R12 again");
    // R4: absent leaf entry
    xlate({10'd0, 10'd18, 12'h0AB}, 1, "R4");

    // R9: nine pages through eight slots
    doFlush();
    for (int i = 0; i < 9; i++) xlate({10'd0, 10'(i), 12'(i * 7)}, 0, "R9 fill");
    xlate({10'd0, 10'd0, 12'h010}, 0, "R9 evicted");
    xlate({10'd0, 10'd2, 12'h020}, 0, "R9 kept");

    // R8: clean cached page then store
    doFlush();
    poke(2048 + 12, {20'hABCDE, 12'h001});
    xlate({10'd0, 10'd12, 12'h004}, 0, "R8 load");
    xlate({10'd0, 10'd12, 12'h008}, 1, "R8 store walks");
    xlate({10'd0, 10'd12, 12'h00C}, 1, "R8 store hits");

    // R10 and R7: stale cached frame until flush
    poke(2048 + 12, {20'h12345, 12'h061});
    xlate({10'd1023, 10'd12, 12'hFFF}, 0, "R7 other root same leaf");
    xlate({10'd0, 10'd12, 12'h100}, 0, "R7 stale hit");
    doFlush();
    xlate({10'd0, 10'd12, 12'h100}, 0, "R10 after flush");

    // random mix
    for (int n = 0; n < 200; n++) begin
      int sel;
      logic [9:0] rIdx;
      sel = int'($urandom_range(0, 3));
      rIdx = (sel == 0) ? 10'd0 : (sel == 1) ? 10'd5 : (sel == 2) ? 10'd1023 : 10'd7;
      if ($urandom_range(0, 19) == 0) doFlush();
      xlate({rIdx, 10'($urandom_range(0, 19)), 12'($urandom)}, 1'($urandom), "random");
    end

    chk(!addrBad, "R2 address range", addrBad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule